// File: doc/BRIEF.md
# Serial Bit Change Detector

This block watches a one-bit serial input that is sampled on every rising clock edge. It flags each place where a sample differs from the sample just before it, which covers both a low-to-high change and a high-to-low change. One interface fits two state machines, and a parameter chooses which one is built.

The registered form has five states. Its output is decoded from the state alone. A change is therefore reported during the clock cycle that follows the edge that captured the second sample of the pair. That output cannot move while the input moves inside a cycle.

The immediate form has three states. Its output is computed from the state and the live input. A change is reported in the same cycle in which the differing value is present on the input, before the edge that captures it. Reset is synchronous and active high. During reset the output is held at 0. The first sample after reset has no predecessor, so it never produces a flag.

Top module: `transition_detector`

## Requirements
- R1: While `rst` is 1 the output `dout` is 0, whichever form is built. In the cycle after a reset cycle, `dout` is also 0.
- R2: Registered form (VARIANT=0): suppose the edge captures a sample that differs from the sample captured at the edge before it, and `rst` was 0 at both edges. Then `dout` is 1 from that edge until the next edge.
- R3: Registered form: suppose the edge captures a sample equal to the sample captured at the edge before it. Then `dout` is 0 for the following cycle.
- R4: Registered form: after the first edge that captures a sample following reset, `dout` is 0.
- R5: Immediate form (VARIANT=1): suppose at least one sample has been captured since reset. If `din` differs from the last captured sample, `dout` is 1 in the same cycle. No clock edge is needed for this.
- R6: Immediate form: if `din` equals the last captured sample, `dout` is 0.
- R7: Immediate form: in the first cycle after reset, no sample has been captured yet, and `dout` is 0 whatever value `din` has.
- R8: The parameter VARIANT selects the form: 0 builds the registered form and 1 builds the immediate form. On a change, the immediate form reports one cycle earlier than the registered form.
- R9: Registered form: `dout` stays constant between clock edges even when `din` changes in the middle of the cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the input is sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data input |
| dout | output | 1 | Change flag |

## Verification
The hardest situation to reach from the ports is the boundary around reset in the middle of a stream. Reset can arrive while the registered form sits in a flagging state, or while the immediate form has a stored sample that differs from the live input. The first sample after reset must then produce no flag, even when it differs from the last sample before reset. The stimulus leaves the machines mid-pattern, asserts reset with an input that would otherwise cause a flag, and releases reset with the opposite value. It also changes the input at the half cycle, so that the timing of the immediate form and the stability of the registered form are observed within one cycle.

// File: rtl/chg_pkg.sv
package chg_pkg;

    localparam int MOORE_SW = 3;
    localparam int MEALY_SW = 2;

    typedef enum logic [MOORE_SW-1:0] {
        MO_IDLE = 3'd0,
        MO_LOW  = 3'd1,
        MO_HIGH = 3'd2,
        MO_RISE = 3'd3,
        MO_FALL = 3'd4
    } moore_st_e;

    typedef enum logic [MEALY_SW-1:0] {
        ME_IDLE = 2'd0,
        ME_LOW  = 2'd1,
        ME_HIGH = 2'd2
    } mealy_st_e;

    typedef struct packed {
        moore_st_e st;
    } moore_nxt_t;

    typedef struct packed {
        mealy_st_e st;
        logic      hit;
    } mealy_nxt_t;

endpackage

// File: rtl/td_moore_core.sv
module td_moore_core
    import chg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    moore_nxt_t nxt_d;
    moore_st_e  st_q;

    always_comb begin
        nxt_d = '{st: MO_IDLE};
        case (st_q)
            MO_IDLE: nxt_d.st = din ? MO_HIGH : MO_LOW;
            MO_LOW:  nxt_d.st = din ? MO_RISE : MO_LOW;
            MO_HIGH: nxt_d.st = din ? MO_HIGH : MO_FALL;
            MO_RISE: nxt_d.st = din ? MO_HIGH : MO_FALL;
            MO_FALL: nxt_d.st = din ? MO_RISE : MO_LOW;
            default: nxt_d.st = MO_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= MO_IDLE;
        end else begin
            st_q <= nxt_d.st;
        end
    end

    assign dout = !rst && ((st_q == MO_RISE) || (st_q == MO_FALL));

    // R2, R3
    moore_xor_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst, 1) && !$past(rst, 2)) |-> (dout == ($past(din, 1) ^ $past(din, 2))));

    // R4
    moore_first_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst, 2) && !$past(rst, 1)) |-> !dout);

endmodule

// File: rtl/td_mealy_core.sv
module td_mealy_core
    import chg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    mealy_nxt_t nxt_d;
    mealy_st_e  st_q;

    always_comb begin
        nxt_d = '{st: ME_IDLE, hit: 1'b0};
        case (st_q)
            ME_IDLE: begin
                nxt_d.st  = din ? ME_HIGH : ME_LOW;
                nxt_d.hit = 1'b0;
            end
            ME_LOW: begin
                nxt_d.st  = din ? ME_HIGH : ME_LOW;
                nxt_d.hit = din;
            end
            ME_HIGH: begin
                nxt_d.st  = din ? ME_HIGH : ME_LOW;
                nxt_d.hit = !din;
            end
            default: begin
                nxt_d.st  = ME_IDLE;
                nxt_d.hit = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ME_IDLE;
        end else begin
            st_q <= nxt_d.st;
        end
    end

    assign dout = !rst && nxt_d.hit;

    // R5, R6
    mealy_xor_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (dout == ($past(din) ^ din)));

    // R7
    mealy_first_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !dout);

endmodule

// File: rtl/transition_detector.sv
module transition_detector #(
    parameter int VARIANT = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    generate
        if (VARIANT == 0) begin : g_moore
            td_moore_core u_core (
                .clk  (clk),
                .rst  (rst),
                .din  (din),
                .dout (dout)
            );
        end else begin : g_mealy
            td_mealy_core u_core (
                .clk  (clk),
                .rst  (rst),
                .din  (din),
                .dout (dout)
            );
        end
    endgenerate

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !dout);

endmodule

// File: tb/sim_transition_detector.sv
`timescale 1ns/100ps
module sim_transition_detector;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic dout_mo;
    logic dout_me;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    bit    q_exp[$];
    string q_tag[$];

    bit have_prev  = 1'b0;
    bit prev_bit   = 1'b0;
    bit moore_hold = 1'b0;

    always #2 clk = ~clk;

    transition_detector #(.VARIANT(0)) u0 (
        .clk(clk), .rst(rst), .din(din), .dout(dout_mo)
    );

    transition_detector #(.VARIANT(1)) u1 (
        .clk(clk), .rst(rst), .din(din), .dout(dout_me)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit b, input bit r);
        bit me_exp;
        bit m;
        string tg;
        @(negedge clk);
        din = b;
        rst = r;
        #1;
        me_exp = r ? 1'b0 : (have_prev ? (prev_bit ^ b) : 1'b0);
        if (r)               tg = "R1";
        else if (!have_prev) tg = "R7";
        else if (me_exp)     tg = "R5";
        else                 tg = "R6";
        check({tg, " immediate"}, dout_me, me_exp);
        check(r ? "R1 registered" : "R9 registered", dout_mo, r ? 1'b0 : moore_hold);
        if (!r && have_prev && (prev_bit ^ b) && !moore_hold) begin
            check("R8 registered lags", dout_mo, 1'b0);
            check("R8 immediate leads", dout_me, 1'b1);
        end
        m = r ? 1'b0 : (have_prev ? (prev_bit ^ b) : 1'b0);
        if (r)               tg = "R1";
        else if (!have_prev) tg = "R4";
        else if (m)          tg = "R2";
        else                 tg = "R3";
        q_exp.push_back(m);
        q_tag.push_back(tg);
        moore_hold = m;
        have_prev  = !r;
        prev_bit   = b;
    endtask

    always @(posedge clk) begin
        #1;
        if (q_exp.size() > 0) begin
            bit e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            check({t, " registered after edge"}, dout_mo, e);
        end
    end

    initial begin
        #1;
        check("R1 reset state registered", dout_mo, 1'b0);
        check("R1 reset state immediate", dout_me, 1'b0);
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        // first sample after reset, then alternating
        for (int i = 0; i < 16; i++) step(i[0], 1'b0);
        // long runs
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
        // reset while a change is pending, released with the opposite value
        step(1'b0, 1'b0);
        step(1'b1, 1'b1);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        // random stream with occasional reset
        for (int i = 0; i < 400; i++) begin
            bit r;
            r = (($urandom % 37) == 0);
            step(1'($urandom), r);
        end
        step(1'b0, 1'b0);
        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule